// File: doc/BRIEF.md
# Windowed Bandwidth Zone Monitor

The block measures how many bytes cross a traffic port during each sampling window. A programmable window timer runs on the block clock. Each valid transfer beat adds its byte count to an accumulator. When the window closes, the total is scaled to count units (bytes shifted right by `UNIT_LOG2`) and clamped to 12 bits. Three programmable thresholds then place the window in one of four zones.

Each zone owns an 8-bit hit counter. The zone a window lands in picks an action byte, and that byte increments or clears any of the four counters. When an increment brings a counter up to its programmed limit, the status bit of that counter's zone is set. A per-zone enable mask and a global enable then produce a level interrupt that software acknowledges in two steps. The block also keeps, for each zone, the largest window total that landed there, so that software can read the peak after an interrupt.

Software uses a 32-bit word-addressed register port with reads that return data in the same cycle. A typical setup brackets the target rate with the medium and high thresholds. It then sets a short limit for the top zone and a long limit for the lower zone, and retunes the thresholds on each interrupt.

Top module: `bw_zone_monitor`

## Requirements
- R1: After reset, `irq` is 0, status and all zone maxima read 0, the hit-limit register (address 6) reads 0xFFFFFFFF, and every other configuration register reads 0.
- R2: With the run bit set, windows follow one another with no gap, each lasting max(WINDOW,1) clock cycles (WINDOW at address 1, bits 23:0). The first window starts on the cycle after the run bit is written.
- R3: The run bit is bit 0 of address 0. While it is 0, beats are ignored, the timer and accumulator are held at zero, and no status bit sets.
- R4: The window value is min(total_bytes >> UNIT_LOG2, 4095). The window is in zone 3 if the value is above HIGH (address 4). Otherwise it is in zone 2 if above MED (address 3), in zone 1 if above LOW (address 2), and in zone 0 if not. A value equal to a threshold stays in the lower zone.
- R5: The landed zone z selects byte z (bits 8z+7:8z) of the action register (address 5). In that byte, the 2-bit slot at bits 2t+1:2t acts on counter t. Slot value 2 increments the counter, which saturates at 255. Any slot value with bit 0 set clears the counter.
- R6: Hit counters change only when a window ends or a counter clear is written. Stopping and restarting the monitor preserves them.
- R7: Byte t of the limit register (address 6) is zone t's limit. Status bit t sets when an increment brings counter t to a value greater than or equal to that limit. A limit of 0xFF never sets it.
- R8: Status (address 8, bit n for zone n) sets only at a window end and holds until software writes 1 to the same bit of address 9. If a set and a clear fall in the same cycle, the set wins.
- R9: Zone maximum z (address 16+z) takes the window value when a window lands in zone z with a value greater than the stored one. It never decreases except by a clear-all.
- R10: Writing address 10 with bit 0 set clears the accumulator, timer and hit counters. Bit 1 does the same and also zeroes the zone maxima. A window ending in the same cycle as a clear is discarded.
- R11: `irq` = global enable (address 11, bit 0) AND a pending flag. The flag is set whenever `status & irq_enable` (address 7) is nonzero. Writing 1 to bit 0 of address 12 drops the flag only if no enabled status bit remains.
- R12: Addresses 9, 10 and 12 are write-only and read as 0. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the sampling tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_valid | input | 1 | A transfer beat is present this cycle |
| beat_bytes | input | BYTES_W | Bytes carried by the beat |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that `beat_bytes` carries a meaningful value whenever `beat_valid` is high. The monotonic-maximum and stable-counter properties take any clear to come only through a register write on the port. The stimulus changes thresholds, limits and actions only while the run bit is 0, so every window is judged against one configuration. Window totals stay within 255 bytes per cycle of window length, which keeps the bench's prediction of each window's zone exact.

// File: rtl/bw_zone_monitor.sv
module bw_zone_monitor #(
  parameter int BYTES_W   = 8,
  parameter int UNIT_LOG2 = 6,
  parameter int WIN_W     = 24,
  parameter int THR_W     = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid,
  input  logic [BYTES_W-1:0] beat_bytes,
  input  logic               reg_wr,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int NZ    = 4;
  localparam int CNT_W = 8;
  localparam int ACC_W = WIN_W + BYTES_W;
  localparam logic [4:0] A_CTRL = 5'd0, A_WIN = 5'd1, A_TLO = 5'd2, A_TMID = 5'd3,
                         A_THI = 5'd4, A_ACT = 5'd5, A_LIM = 5'd6, A_IEN = 5'd7,
                         A_STAT = 5'd8, A_ICLR = 5'd9, A_CCLR = 5'd10, A_GEN = 5'd11,
                         A_GCLR = 5'd12;

  logic             run_q, gen_q, gpend_q;
  logic [WIN_W-1:0] win_q, tick_q;
  logic [THR_W-1:0] tlo_q, tmid_q, thi_q;
  logic [31:0]      act_q, lim_q;
  logic [NZ-1:0]    ien_q, stat_q, fire;
  logic [ACC_W-1:0] acc_q;
  logic [NZ*CNT_W-1:0] hit_flat;
  logic [NZ*THR_W-1:0] zmax_flat;

  wire we_ctrl = reg_wr && reg_addr == A_CTRL;
  wire we_win  = reg_wr && reg_addr == A_WIN;
  wire we_tlo  = reg_wr && reg_addr == A_TLO;
  wire we_tmid = reg_wr && reg_addr == A_TMID;
  wire we_thi  = reg_wr && reg_addr == A_THI;
  wire we_act  = reg_wr && reg_addr == A_ACT;
  wire we_lim  = reg_wr && reg_addr == A_LIM;
  wire we_ien  = reg_wr && reg_addr == A_IEN;
  wire we_iclr = reg_wr && reg_addr == A_ICLR;
  wire we_cclr = reg_wr && reg_addr == A_CCLR;
  wire we_gen  = reg_wr && reg_addr == A_GEN;
  wire we_gclr = reg_wr && reg_addr == A_GCLR;

  wire cclr_all  = we_cclr && reg_wdata[1];
  wire cclr_cur  = we_cclr && (reg_wdata[0] || reg_wdata[1]);
  wire gclr      = we_gclr && reg_wdata[0];
  wire local_any = |(stat_q & ien_q);

  logic [WIN_W:0] tick_nx;
  assign tick_nx = {1'b0, tick_q} + {{WIN_W{1'b0}}, 1'b1};
  wire win_end = run_q && (tick_nx >= {1'b0, win_q});
  wire wend    = win_end && !cclr_cur;

  logic [ACC_W-1:0] total, units;
  logic [THR_W-1:0] sat;
  logic [1:0]       zone;
  logic [7:0]       fld;
  assign total = acc_q + {{(ACC_W-BYTES_W){1'b0}}, (beat_valid ? beat_bytes : {BYTES_W{1'b0}})};
  assign units = total >> UNIT_LOG2;
  assign sat   = (|units[ACC_W-1:THR_W]) ? {THR_W{1'b1}} : units[THR_W-1:0];
  assign zone  = (sat > thi_q) ? 2'd3 : (sat > tmid_q) ? 2'd2 : (sat > tlo_q) ? 2'd1 : 2'd0;
  assign fld   = act_q[{zone, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; win_q <= '0; tlo_q <= '0; tmid_q <= '0; thi_q <= '0;
      act_q <= '0; lim_q <= '1; ien_q <= '0; gen_q <= 1'b0;
    end else begin
      if (we_ctrl) run_q  <= reg_wdata[0];
      if (we_win)  win_q  <= reg_wdata[WIN_W-1:0];
      if (we_tlo)  tlo_q  <= reg_wdata[THR_W-1:0];
      if (we_tmid) tmid_q <= reg_wdata[THR_W-1:0];
      if (we_thi)  thi_q  <= reg_wdata[THR_W-1:0];
      if (we_act)  act_q  <= reg_wdata;
      if (we_lim)  lim_q  <= reg_wdata;
      if (we_ien)  ien_q  <= reg_wdata[NZ-1:0];
      if (we_gen)  gen_q  <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0; acc_q <= '0;
    end else if (!run_q || cclr_cur || win_end) begin
      tick_q <= '0; acc_q <= '0;
    end else begin
      tick_q <= tick_nx[WIN_W-1:0]; acc_q <= total;
    end
  end

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    logic [CNT_W-1:0] hit_q, hit_up;
    logic [THR_W-1:0] zmax_q;
    wire [1:0]       slot = fld[2*z +: 2];
    wire [CNT_W-1:0] lim  = lim_q[CNT_W*z +: CNT_W];
    wire inc = wend && slot == 2'b10;
    wire clr = wend && slot[0];
    assign hit_up  = (hit_q == {CNT_W{1'b1}}) ? hit_q : hit_q + 1'b1;
    assign fire[z] = inc && hit_up >= lim && lim != {CNT_W{1'b1}};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hit_q <= '0;
      else if (cclr_cur || clr)  hit_q <= '0;
      else if (inc)              hit_q <= hit_up;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   zmax_q <= '0;
      else if (cclr_all)                            zmax_q <= '0;
      else if (wend && zone == z && sat > zmax_q)   zmax_q <= sat;
    end
    assign hit_flat[CNT_W*z +: CNT_W]  = hit_q;
    assign zmax_flat[THR_W*z +: THR_W] = zmax_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0; gpend_q <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~(we_iclr ? reg_wdata[NZ-1:0] : {NZ{1'b0}})) | fire;
      gpend_q <= local_any || (gpend_q && !gclr);
    end
  end

  assign irq = gen_q && gpend_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) begin
      if (reg_addr[3:2] == 2'b00)
        reg_rdata[THR_W-1:0] = zmax_flat[THR_W*reg_addr[1:0] +: THR_W];
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata[0]         = run_q;
        A_WIN:   reg_rdata[WIN_W-1:0] = win_q;
        A_TLO:   reg_rdata[THR_W-1:0] = tlo_q;
        A_TMID:  reg_rdata[THR_W-1:0] = tmid_q;
        A_THI:   reg_rdata[THR_W-1:0] = thi_q;
        A_ACT:   reg_rdata            = act_q;
        A_LIM:   reg_rdata            = lim_q;
        A_IEN:   reg_rdata[NZ-1:0]    = ien_q;
        A_STAT:  reg_rdata[NZ-1:0]    = stat_q;
        A_GEN:   reg_rdata[0]         = gen_q;
        default: reg_rdata            = '0;
      endcase
    end
  end
endmodule

module bw_zone_monitor_chk #(
  parameter int THR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic [3:0]        stat_q,
  input logic              wend,
  input logic              cclr,
  input logic              cclr_all,
  input logic [31:0]       hit_flat,
  input logic [4*THR_W-1:0] zmax_flat,
  input logic              gclr,
  input logic              local_any,
  input logic              gen_q,
  input logic              irq
);
  // R3
  idle_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> ((stat_q & ~$past(stat_q)) == 4'b0));

  // R8
  stat_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) != 4'b0) |-> $past(wend));

  // R6
  hits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wend && !cclr) |=> $stable(hit_flat));

  // R11
  gclr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gclr && local_any && gen_q) |=> irq);

  for (genvar z = 0; z < 4; z++) begin : g_mono
    // R9
    zmax_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cclr_all |=> zmax_flat[THR_W*z +: THR_W] >= $past(zmax_flat[THR_W*z +: THR_W]));
  end
endmodule

bind bw_zone_monitor bw_zone_monitor_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .stat_q(stat_q), .wend(wend),
  .cclr(cclr_cur), .cclr_all(cclr_all), .hit_flat(hit_flat), .zmax_flat(zmax_flat),
  .gclr(gclr), .local_any(local_any), .gen_q(gen_q), .irq(irq)
);

// File: tb/tb_bw_zone_monitor.sv
module tb_bw_zone_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic beat_valid = 1'b0, reg_wr = 1'b0;
  logic [7:0] beat_bytes = '0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int nchk = 0, nfail = 0, W = 4;
  bit done = 0;
  int lo, mid, hi;
  logic [31:0] act, lim;
  int mcnt[4], mzmax[4];
  logic [3:0] mstat;
  localparam logic [31:0] STD_ACT = 32'h95250901;

  always #10 clk = ~clk;

  bw_zone_monitor #(.BYTES_W(8), .UNIT_LOG2(1)) dut (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic window(input int total);
    int rem = total;
    for (int c = 0; c < W; c++) begin
      int b = rem > 255 ? 255 : rem;
      beat_valid = b != 0; beat_bytes = 8'(b); rem -= b;
      @(negedge clk);
    end
    beat_valid = 1'b0; beat_bytes = '0;
  endtask

  function automatic int exp_units(input int total);
    int u = total >> 1;
    return u > 4095 ? 4095 : u;
  endfunction

  function automatic int exp_zone(input int u);
    if (u > hi) return 3;
    if (u > mid) return 2;
    if (u > lo) return 1;
    return 0;
  endfunction

  task automatic model_window(input int total);
    int u = exp_units(total);
    int z = exp_zone(u);
    logic [7:0] f = act[8*z +: 8];
    if (u > mzmax[z]) mzmax[z] = u;
    for (int t = 0; t < 4; t++) begin
      logic [1:0] s = f[2*t +: 2];
      int l = int'(lim[8*t +: 8]);
      if (s[0]) mcnt[t] = 0;
      else if (s == 2'b10) begin
        if (mcnt[t] < 255) mcnt[t]++;
        if (l != 255 && mcnt[t] >= l) mstat[t] = 1'b1;
      end
    end
  endtask

  task automatic check_model();
    logic [31:0] d;
    rd(5'd8, d); check("R7/R8 status vs model", d, {28'd0, mstat});
    for (int z = 0; z < 4; z++) begin
      rd(5'(16 + z), d); check("R4/R9 zone max vs model", d, 32'(mzmax[z]));
    end
  endtask

  task automatic config_all();
    wr(5'd1, 32'(W)); wr(5'd2, 32'(lo)); wr(5'd3, 32'(mid)); wr(5'd4, 32'(hi));
    wr(5'd5, act); wr(5'd6, lim);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(5'd8, d);  check("R1 status after reset", d, 32'd0);
    rd(5'd19, d); check("R1 zone max after reset", d, 32'd0);
    rd(5'd6, d);  check("R1 limit after reset", d, 32'hFFFFFFFF);
    rd(5'd1, d);  check("R1 window after reset", d, 32'd0);

    // R3 beats ignored while stopped
    W = 4; lo = 10; mid = 20; hi = 30; act = STD_ACT; lim = 32'h01010101;
    config_all();
    for (int c = 0; c < 30; c++) begin
      beat_valid = 1'b1; beat_bytes = 8'd255; @(negedge clk);
    end
    beat_valid = 1'b0;
    rd(5'd8, d);  check("R3 no status while stopped", d, 32'd0);
    rd(5'd19, d); check("R3 no zone max while stopped", d, 32'd0);

    // R2 window length
    W = 6; wr(5'd1, 32'd6); wr(5'd0, 32'd1);
    for (int c = 0; c < 5; c++) begin
      beat_valid = 1'b1; beat_bytes = 8'd255; @(negedge clk);
    end
    rd(5'd8, d); check("R2 no result before window end", d, 32'd0);
    @(negedge clk); beat_valid = 1'b0;
    rd(5'd8, d);  check("R2 result at window end", d, 32'h8);
    rd(5'd19, d); check("R9 zone3 max captured", d, 32'd765);
    wr(5'd0, 32'd0);

    // R4 threshold equality and saturation
    wr(5'd9, 32'hF); W = 4; wr(5'd1, 32'd4); wr(5'd0, 32'd1);
    window(20);
    rd(5'd16, d); check("R4 equal to low stays zone0", d, 32'd10);
    rd(5'd17, d); check("R4 zone1 untouched", d, 32'd0);
    window(22);
    rd(5'd17, d); check("R4 above low is zone1", d, 32'd11);
    rd(5'd8, d);  check("R7 zone1 limit 1 fires", d & 32'h2, 32'h2);
    window(60);
    rd(5'd18, d); check("R4 equal to high stays zone2", d, 32'd30);
    rd(5'd19, d); check("R4 zone3 unchanged", d, 32'd765);
    wr(5'd0, 32'd0);
    W = 40; wr(5'd1, 32'd40); wr(5'd0, 32'd1);
    window(40 * 255);
    rd(5'd19, d); check("R4 saturation to 4095", d, 32'd4095);
    wr(5'd0, 32'd0);

    // R10 counter clears, R12 write-only reads
    wr(5'd10, 32'd1);
    rd(5'd19, d); check("R10 bit0 keeps zone max", d, 32'd4095);
    rd(5'd10, d); check("R12 counter clear reads zero", d, 32'd0);
    wr(5'd10, 32'd2);
    rd(5'd19, d); check("R10 bit1 zeroes zone max", d, 32'd0);
    rd(5'd16, d); check("R10 bit1 zeroes zone0 max", d, 32'd0);
    wr(5'd9, 32'hF);
    rd(5'd9, d);  check("R12 irq clear reads zero", d, 32'd0);
    rd(5'd8, d);  check("R8 status cleared by write", d, 32'd0);

    // R5 R6 R7 actions, persistence and limits
    lim = 32'hFF010301; wr(5'd6, lim);
    W = 4; wr(5'd1, 32'd4); wr(5'd0, 32'd1);
    window(22); window(22);
    wr(5'd0, 32'd0);
    repeat (20) @(negedge clk);
    rd(5'd8, d); check("R6 no fire after two hits", d, 32'd0);
    wr(5'd0, 32'd1);
    window(22);
    rd(5'd8, d); check("R6 count kept across stop, third hit fires", d, 32'h2);
    wr(5'd0, 32'd0); wr(5'd9, 32'hF); wr(5'd0, 32'd1);
    window(100); window(22); window(22);
    rd(5'd8, d); check("R5 zone3 action cleared zone1 count", d, 32'd0);
    window(22);
    rd(5'd8, d); check("R5 zone1 fires after three new hits", d, 32'h2);
    check("R7 limit 0xFF suppresses zone3", d & 32'h8, 32'd0);

    // R11 interrupt gating and two-step acknowledge
    wr(5'd0, 32'd0);
    wr(5'd7, 32'h2);
    @(negedge clk);
    check("R11 irq gated by global enable", {31'd0, irq}, 32'd0);
    wr(5'd11, 32'd1);
    check("R11 irq asserted", {31'd0, irq}, 32'd1);
    wr(5'd12, 32'd1);
    check("R11 global clear with status pending", {31'd0, irq}, 32'd1);
    wr(5'd9, 32'h2);
    rd(5'd8, d); check("R8 status bit1 cleared", d, 32'd0);
    check("R11 irq held until global clear", {31'd0, irq}, 32'd1);
    wr(5'd12, 32'd1);
    check("R11 irq dropped after ordered clear", {31'd0, irq}, 32'd0);
    rd(5'd12, d); check("R12 global clear reads zero", d, 32'd0);
    wr(5'd11, 32'd0); wr(5'd7, 32'd0);

    // random phases against the bench model
    for (int p = 0; p < 3; p++) begin
      int a, b, c;
      wr(5'd0, 32'd0); wr(5'd10, 32'd3); wr(5'd9, 32'hF);
      mstat = '0;
      for (int z = 0; z < 4; z++) begin mcnt[z] = 0; mzmax[z] = 0; end
      a = $urandom_range(0, 1100); b = $urandom_range(0, 1100); c = $urandom_range(0, 1100);
      lo = a < b ? (a < c ? a : c) : (b < c ? b : c);
      hi = a > b ? (a > c ? a : c) : (b > c ? b : c);
      mid = a + b + c - lo - hi;
      act = (p == 2) ? $urandom() : STD_ACT;
      for (int z = 0; z < 4; z++)
        lim[8*z +: 8] = ($urandom_range(0, 4) == 0) ? 8'hFF : 8'($urandom_range(0, 5));
      W = 8;
      config_all();
      wr(5'd0, 32'd1);
      for (int k = 0; k < 25; k++) begin
        int tot = $urandom_range(0, 255 * W);
        window(tot);
        model_window(tot);
        check_model();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule